// File: doc/BRIEF.md
# Multi-Lane Serial Flash Frame Sequencer

This block runs one serial flash transaction (a frame) at a time over one, two or four data lines. A frame is a number of bytes set by a total byte count. A command byte count splits the frame into two parts. Bytes below the command count form the command phase: they are taken from a ready/valid transmit source and sent, and anything sampled during them is discarded. The remaining bytes form the data phase: their received values are returned one byte per `rx_valid_o` pulse. An optional run of idle serial clocks can be placed between the two phases.

A two-bit lane-mode code chooses which bytes use one line and which use the wide lanes. A width bit sets the wide lanes to two or four lines. The serial clock runs at a programmable fraction of the system clock, and its resting level is selectable. Chip select frames the transaction. A ready flag and a pair of completion pulses let a controller start the next frame. The engine stalls at byte boundaries when the next transmit byte is not yet available or when there is no room for a received byte.

Top module: `flash_frame_seq`

## Requirements
- R1: `ready_o` is 1 exactly when no frame is in progress. A `start_i` pulse while ready latches the configuration and begins a frame. A start with total byte count 0 is ignored: `ready_o` stays 1 and no serial clock is produced.
- R2: A byte whose index is below the command count is a command byte. Each command byte is taken by one `tx_valid_i`/`tx_ready_o` handshake, in order, and shifted out most significant bit first. Command bytes produce no `rx_valid_o`.
- R3: Every data byte (index at or above the command count) returns exactly one `rx_valid_o` pulse carrying the received byte. In single-lane use a data byte drives line 0 with the dummy value 0xFF. On the wide lanes a data byte drives no line.
- R4: Lane mode 00 uses one lane for every byte: output on line 0 (`dq_oe_o` = 0001), input sampled from line 1.
- R5: Lane mode 01 sends all command bytes on line 0 and the data bytes on the wide lanes. Mode 10 sends only byte 0, when it is a command byte, on line 0, and every other byte wide. Mode 11 sends every byte wide.
- R6: With `quad_i` = 0 the wide lanes are lines 1..0, with 4 clocks per byte. With `quad_i` = 1 they are lines 3..0, with 2 clocks per byte. The highest line carries the most significant bit of each chunk, both in and out.
- R7: When idle count K is nonzero and the frame has data bytes, K serial clock cycles with all drive enables at 0 are inserted after the last command byte.
- R8: Within a byte, consecutive rising serial clock edges are 2×N system clocks apart, where N is `clk_div_i`. A value of 0 acts as 1.
- R9: While chip select is high, `sclk_o` equals `clk_idle_hi_i`. Data is sampled on the rising serial clock edge in both idle levels.
- R10: `cs_no` is low from frame start until the final byte finishes and high otherwise. Drive enables are 0 while it is high.
- R11: `tx_done_o` and `rx_done_o` pulse together for one cycle at the end of each frame. `ready_o` is 1 in the following cycle.
- R12: The serial clock does not advance while the next command byte has no `tx_valid_i`, or while the next data byte has no `rx_space_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a frame (accepted when ready) |
| total_bytes_i | input | 16 | Bytes in the frame |
| cmd_bytes_i | input | 9 | Command phase byte count |
| idle_clks_i | input | 4 | Idle serial clocks between phases |
| lane_mode_i | input | 2 | Lane usage code |
| quad_i | input | 1 | Wide lanes: 0 two lines, 1 four lines |
| clk_div_i | input | 4 | Serial clock half-period in system clocks |
| clk_idle_hi_i | input | 1 | Serial clock resting level |
| tx_data_i | input | 8 | Transmit byte |
| tx_valid_i | input | 1 | Transmit byte available |
| tx_ready_o | output | 1 | Transmit byte taken |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | Received byte strobe |
| rx_space_i | input | 1 | Room for a received byte |
| sclk_o | output | 1 | Serial clock |
| cs_no | output | 1 | Chip select, active low |
| dq_i | input | 4 | Data lines in |
| dq_o | output | 4 | Data lines out |
| dq_oe_o | output | 4 | Per-line drive enable |
| tx_done_o | output | 1 | Frame transmit complete pulse |
| rx_done_o | output | 1 | Frame receive complete pulse |
| ready_o | output | 1 | No frame in progress |

## Verification
In a read frame, the final data byte delivers its `rx_valid_o` in the same cycle that the two completion pulses rise. A controller that retires the frame on the done pulse can therefore drop the last byte. Every table frame with a data phase ends on a data byte, so this collision is provoked on each of them. The received-byte monitor samples on every falling system-clock edge. The byte count and values are judged only one cycle after the done pulse, and the count must equal the number of data bytes, last one included.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;
  typedef enum logic [1:0] {LN_1 = 2'd0, LN_2 = 2'd1, LN_4 = 2'd2} lanes_e;
  typedef enum logic [2:0] {ST_IDLE, ST_LOAD, ST_SHIFT, ST_GAP, ST_FIN} state_e;

  function automatic lanes_e pick_lanes(input logic [1:0] mode, input logic quad,
                                        input logic first, input logic cmd);
    logic wide;
    wide = (mode == 2'b11) | ((mode == 2'b10) & !(first & cmd)) | ((mode == 2'b01) & !cmd);
    if (!wide) return LN_1;
    return quad ? LN_4 : LN_2;
  endfunction

  function automatic logic [3:0] lane_mask(input lanes_e l);
    case (l)
      LN_2:    return 4'b0011;
      LN_4:    return 4'b1111;
      default: return 4'b0001;
    endcase
  endfunction

  function automatic logic [3:0] clks_per_byte(input lanes_e l);
    case (l)
      LN_2:    return 4'd4;
      LN_4:    return 4'd2;
      default: return 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/fs_tick_gen.sv
module fs_tick_gen #(
  parameter int DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] n_eff;

  assign n_eff  = (div_i == '0) ? DIV_W'(1) : div_i;
  assign tick_o = run_i && (cnt_q == n_eff - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/fs_lane_shifter.sv
module fs_lane_shifter
  import frame_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] byte_i,
  input  logic       shift_i,
  input  logic       sample_i,
  input  lanes_e     lanes_i,
  input  logic [3:0] dq_i,
  output logic [3:0] dq_bits_o,
  output logic [7:0] rx_byte_o
);
  logic [7:0] tx_q, rx_q;

  always_comb begin
    case (lanes_i)
      LN_2:    dq_bits_o = {2'b00, tx_q[7:6]};
      LN_4:    dq_bits_o = tx_q[7:4];
      default: dq_bits_o = {3'b000, tx_q[7]};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load_i) tx_q <= byte_i;
      else if (shift_i) begin
        case (lanes_i)
          LN_2:    tx_q <= {tx_q[5:0], 2'b00};
          LN_4:    tx_q <= {tx_q[3:0], 4'b0000};
          default: tx_q <= {tx_q[6:0], 1'b0};
        endcase
      end
      if (sample_i) begin
        case (lanes_i)
          LN_2:    rx_q <= {rx_q[5:0], dq_i[1:0]};
          LN_4:    rx_q <= {rx_q[3:0], dq_i[3:0]};
          default: rx_q <= {rx_q[6:0], dq_i[1]};
        endcase
      end
    end
  end

  assign rx_byte_o = rx_q;
endmodule

// File: rtl/flash_frame_seq.sv
module flash_frame_seq
  import frame_seq_pkg::*;
#(
  parameter int TOT_W  = 16,
  parameter int CMD_W  = 9,
  parameter int IDLE_W = 4,
  parameter int DIV_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [TOT_W-1:0]  total_bytes_i,
  input  logic [CMD_W-1:0]  cmd_bytes_i,
  input  logic [IDLE_W-1:0] idle_clks_i,
  input  logic [1:0]        lane_mode_i,
  input  logic              quad_i,
  input  logic [DIV_W-1:0]  clk_div_i,
  input  logic              clk_idle_hi_i,
  input  logic [7:0]        tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [7:0]        rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_space_i,
  output logic              sclk_o,
  output logic              cs_no,
  input  logic [3:0]        dq_i,
  output logic [3:0]        dq_o,
  output logic [3:0]        dq_oe_o,
  output logic              tx_done_o,
  output logic              rx_done_o,
  output logic              ready_o
);
  localparam int CMP_W = (TOT_W > CMD_W) ? TOT_W : CMD_W;

  state_e            st_q;
  logic [TOT_W-1:0]  tot_q, idx_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [IDLE_W-1:0] gap_cfg_q, gap_left_q;
  logic [1:0]        mode_q;
  logic              quad_q;
  logic [DIV_W-1:0]  div_q;
  logic              ph_q;
  logic [3:0]        clk_left_q;
  lanes_e            lanes_q, lanes_nx;
  logic              tx_byte_q;
  logic              rx_valid_q;
  logic [7:0]        rx_data_q;

  logic [CMP_W-1:0]  idx_x, cmd_x;
  logic is_cmd, run, tick, rise, fall, last_clk, last_byte, gap_next, load_go, byte_end;
  logic [3:0] dq_bits;
  logic [7:0] rx_byte;

  assign idx_x     = CMP_W'(idx_q);
  assign cmd_x     = CMP_W'(cmd_q);
  assign is_cmd    = idx_x < cmd_x;
  assign lanes_nx  = pick_lanes(mode_q, quad_q, idx_q == '0, is_cmd);
  assign run       = (st_q == ST_SHIFT) || (st_q == ST_GAP);
  assign rise      = tick && !ph_q;
  assign fall      = tick && ph_q;
  assign last_clk  = clk_left_q == 4'd1;
  assign last_byte = idx_q == tot_q - TOT_W'(1);
  assign gap_next  = ((idx_x + CMP_W'(1)) == cmd_x) && (gap_cfg_q != '0);
  assign load_go   = (st_q == ST_LOAD) && (is_cmd ? tx_valid_i : rx_space_i);
  assign byte_end  = (st_q == ST_SHIFT) && fall && last_clk;

  fs_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .div_i(div_q), .tick_o(tick)
  );

  fs_lane_shifter u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_go),
    .byte_i   (is_cmd ? tx_data_i : 8'hFF),
    .shift_i  ((st_q == ST_SHIFT) && fall && !last_clk),
    .sample_i ((st_q == ST_SHIFT) && rise),
    .lanes_i  (lanes_q),
    .dq_i     (dq_i),
    .dq_bits_o(dq_bits),
    .rx_byte_o(rx_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      tot_q      <= '0;
      idx_q      <= '0;
      cmd_q      <= '0;
      gap_cfg_q  <= '0;
      gap_left_q <= '0;
      mode_q     <= '0;
      quad_q     <= 1'b0;
      div_q      <= '0;
      ph_q       <= 1'b0;
      clk_left_q <= '0;
      lanes_q    <= LN_1;
      tx_byte_q  <= 1'b0;
      rx_valid_q <= 1'b0;
      rx_data_q  <= '0;
    end else begin
      rx_valid_q <= byte_end && !tx_byte_q;
      if (byte_end && !tx_byte_q) rx_data_q <= rx_byte;
      case (st_q)
        ST_IDLE: if (start_i && total_bytes_i != '0) begin
          tot_q     <= total_bytes_i;
          cmd_q     <= cmd_bytes_i;
          gap_cfg_q <= idle_clks_i;
          mode_q    <= lane_mode_i;
          quad_q    <= quad_i;
          div_q     <= clk_div_i;
          idx_q     <= '0;
          ph_q      <= 1'b0;
          st_q      <= ST_LOAD;
        end
        ST_LOAD: if (load_go) begin
          lanes_q    <= lanes_nx;
          tx_byte_q  <= is_cmd;
          clk_left_q <= clks_per_byte(lanes_nx);
          ph_q       <= 1'b0;
          st_q       <= ST_SHIFT;
        end
        ST_SHIFT: if (tick) begin
          ph_q <= !ph_q;
          if (fall) begin
            if (!last_clk) clk_left_q <= clk_left_q - 4'd1;
            else if (last_byte) st_q <= ST_FIN;
            else begin
              idx_q <= idx_q + TOT_W'(1);
              if (gap_next) begin
                gap_left_q <= gap_cfg_q;
                st_q       <= ST_GAP;
              end else st_q <= ST_LOAD;
            end
          end
        end
        ST_GAP: if (tick) begin
          ph_q <= !ph_q;
          if (fall) begin
            if (gap_left_q == IDLE_W'(1)) st_q <= ST_LOAD;
            else gap_left_q <= gap_left_q - IDLE_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // dummy bytes drive line 0 only in single-lane use; wide data bytes release the lines
  assign dq_oe_o    = ((st_q == ST_SHIFT) && (tx_byte_q || lanes_q == LN_1)) ? lane_mask(lanes_q) : 4'b0000;
  assign dq_o       = dq_bits & dq_oe_o;
  assign sclk_o     = (st_q == ST_IDLE) ? clk_idle_hi_i : ph_q;
  assign cs_no      = st_q == ST_IDLE;
  assign ready_o    = st_q == ST_IDLE;
  assign tx_ready_o = (st_q == ST_LOAD) && is_cmd;
  assign tx_done_o  = st_q == ST_FIN;
  assign rx_done_o  = st_q == ST_FIN;
  assign rx_valid_o = rx_valid_q;
  assign rx_data_o  = rx_data_q;
endmodule

// File: rtl/flash_frame_seq_chk.sv
module flash_frame_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       clk_idle_hi_i,
  input logic       tx_valid_i,
  input logic       tx_ready_o,
  input logic       rx_valid_o,
  input logic       sclk_o,
  input logic       cs_no,
  input logic [3:0] dq_oe_o,
  input logic       tx_done_o,
  input logic       rx_done_o,
  input logic       ready_o
);
  a_r1_ready_cs: assert property (@(posedge clk_i) disable iff (!rst_ni) ready_o == cs_no);
  a_r11_done_pair: assert property (@(posedge clk_i) disable iff (!rst_ni) tx_done_o == rx_done_o);
  a_r11_done_ready: assert property (@(posedge clk_i) disable iff (!rst_ni) tx_done_o |=> ready_o);
  a_r12_stall_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ready_o && !tx_valid_i) |=> $stable(sclk_o));
  a_r10_cs_release: assert property (@(posedge clk_i) disable iff (!rst_ni) cs_no |-> (dq_oe_o == 4'b0000));
  a_r9_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni) cs_no |-> (sclk_o == clk_idle_hi_i));
  a_r3_rx_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni) rx_valid_o |-> !cs_no);
endmodule

bind flash_frame_seq flash_frame_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clk_idle_hi_i(clk_idle_hi_i), .tx_valid_i(tx_valid_i),
  .tx_ready_o(tx_ready_o), .rx_valid_o(rx_valid_o), .sclk_o(sclk_o), .cs_no(cs_no),
  .dq_oe_o(dq_oe_o), .tx_done_o(tx_done_o), .rx_done_o(rx_done_o), .ready_o(ready_o)
);

// File: tb/sim_flash_frame_seq.sv
`timescale 1ns/1ps
module sim_flash_frame_seq;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, start, quad, cpol, tx_valid, tx_ready, rx_valid, rx_space;
  logic sclk, cs_n, tx_done, rx_done, ready;
  logic [15:0] total;
  logic [8:0]  cmd;
  logic [3:0]  idle, div, dq_in, dq_out, dq_oe;
  logic [1:0]  mode;
  logic [7:0]  tx_data, rx_data;

  flash_frame_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .total_bytes_i(total), .cmd_bytes_i(cmd),
    .idle_clks_i(idle), .lane_mode_i(mode), .quad_i(quad), .clk_div_i(div), .clk_idle_hi_i(cpol),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .rx_data_o(rx_data),
    .rx_valid_o(rx_valid), .rx_space_i(rx_space), .sclk_o(sclk), .cs_no(cs_n), .dq_i(dq_in),
    .dq_o(dq_out), .dq_oe_o(dq_oe), .tx_done_o(tx_done), .rx_done_o(rx_done), .ready_o(ready)
  );

  typedef struct packed {
    logic [7:0] tot; logic [7:0] cmd; logic [3:0] idle; logic [1:0] mode;
    logic quad; logic [3:0] div; logic cpol;
  } vec_t;

  localparam vec_t VEC [0:8] = '{
    '{8'd1, 8'd1, 4'd0, 2'b00, 1'b0, 4'd2, 1'b0},
    '{8'd1, 8'd0, 4'd0, 2'b00, 1'b0, 4'd1, 1'b0},
    '{8'd6, 8'd4, 4'd2, 2'b00, 1'b0, 4'd3, 1'b0},
    '{8'd5, 8'd4, 4'd0, 2'b01, 1'b1, 4'd1, 1'b0},
    '{8'd6, 8'd4, 4'd4, 2'b01, 1'b0, 4'd2, 1'b1},
    '{8'd5, 8'd1, 4'd3, 2'b10, 1'b1, 4'd0, 1'b0},
    '{8'd5, 8'd3, 4'd2, 2'b11, 1'b1, 4'd1, 1'b0},
    '{8'd4, 8'd4, 4'd0, 2'b11, 1'b0, 4'd1, 1'b1},
    '{8'd3, 8'd0, 4'd0, 2'b10, 1'b0, 4'd2, 1'b1}
  };

  function automatic logic [7:0] tx_fn(input int i);
    return 8'(32'h5A ^ (i * 37));
  endfunction
  function automatic logic [3:0] rx_fn(input int n);
    return 4'(n * 5 + 3);
  endfunction

  int n_chk = 0, n_bad = 0, cyc = 0;
  int rise_cnt = 0, tx_idx = 0, rx_cnt = 0;
  logic prev_sclk = 1'b0, hs_pend = 1'b0, wd_hit = 1'b0;
  logic [3:0] rec_dq [0:511];
  logic [3:0] rec_oe [0:511];
  int         rec_t  [0:511];
  logic [7:0] rx_rec [0:63];
  logic [3:0] exp_dq [0:511];
  logic [3:0] exp_oe [0:511];
  logic [7:0] exp_rx [0:63];
  int exp_rises, exp_rx_n, exp_tx_n, exp_stop;

  assign tx_data = tx_fn(tx_idx);
  assign dq_in   = rx_fn(rise_cnt);

  always @(negedge clk) begin
    cyc++;
    if (hs_pend) tx_idx++;
    hs_pend = tx_valid && tx_ready;
    if (!cs_n && !prev_sclk && sclk) begin
      if (rise_cnt < 512) begin
        rec_dq[rise_cnt] = dq_out;
        rec_oe[rise_cnt] = dq_oe;
        rec_t[rise_cnt]  = cyc;
      end
      rise_cnt++;
    end
    prev_sclk = sclk;
    if (rx_valid) begin
      if (rx_cnt < 64) rx_rec[rx_cnt] = rx_data;
      rx_cnt++;
    end
    if (cyc > 150000 && !wd_hit) begin
      wd_hit = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic build_exp(input vec_t v);
    int r = 0, t = 0, nrx = 0;
    exp_stop = -1;
    for (int b = 0; b < int'(v.tot); b++) begin
      bit isc = b < int'(v.cmd);
      bit wide = (v.mode == 2'b11) || (v.mode == 2'b10 && !(b == 0 && isc)) || (v.mode == 2'b01 && !isc);
      int w = !wide ? 1 : (v.quad ? 4 : 2);
      int m = (1 << w) - 1;
      logic [7:0] byt = isc ? tx_fn(t) : 8'hFF;
      logic [7:0] acc = '0;
      if (!isc && exp_stop < 0) exp_stop = r;
      if (isc) t++;
      for (int k = 0; k < 8 / w; k++) begin
        logic [3:0] v4 = rx_fn(r);
        logic [3:0] ch = 4'((int'(byt) >> (8 - w * (k + 1))) & m);
        if (isc || w == 1) begin exp_oe[r] = 4'(m); exp_dq[r] = ch; end
        else begin exp_oe[r] = '0; exp_dq[r] = '0; end
        acc = (w == 1) ? {acc[6:0], v4[1]} : 8'((int'(acc) << w) | (int'(v4) & m));
        r++;
      end
      if (!isc) begin exp_rx[nrx] = acc; nrx++; end
      if (b + 1 == int'(v.cmd) && b + 1 < int'(v.tot) && v.idle != 0)
        for (int i = 0; i < int'(v.idle); i++) begin exp_oe[r] = '0; exp_dq[r] = '0; r++; end
    end
    exp_rises = r; exp_rx_n = nrx; exp_tx_n = t;
  endtask

  task automatic run_frame(input vec_t v, input int stall);
    string tg;
    int w = 0, bad = 0;
    tg = (v.mode == 2'b00) ? "R4" : (v.quad ? "R5 R6" : "R5");
    if (v.idle != 0) tg = {tg, " R7"};
    @(negedge clk);
    total = {8'd0, v.tot}; cmd = {1'b0, v.cmd}; idle = v.idle; mode = v.mode;
    quad = v.quad; div = v.div; cpol = v.cpol;
    tx_valid = (stall != 1); rx_space = (stall != 2);
    @(posedge clk);
    rise_cnt = 0; tx_idx = 0; rx_cnt = 0;
    @(negedge clk);
    chk(sclk == v.cpol, "R9", "idle level before frame", int'(sclk), int'(v.cpol));
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    build_exp(v);
    if (stall != 0) begin
      int stop = (stall == 1) ? 0 : exp_stop;
      repeat (60) @(negedge clk);
      chk(rise_cnt == stop, "R12", "rises while stalled", rise_cnt, stop);
      chk(!cs_n && !ready, "R10 R1", "cs low and not ready in stall", int'(cs_n), 0);
      tx_valid = 1'b1; rx_space = 1'b1;
    end
    while (!tx_done && w < 5000) begin @(negedge clk); w++; end
    chk(tx_done && rx_done, "R11", "done pulses together", int'(rx_done), 1);
    @(negedge clk);
    chk(ready && cs_n, "R11 R10", "ready and cs high after done", int'(ready), 1);
    chk(!tx_done, "R11", "done lasts one cycle", int'(tx_done), 0);
    chk(sclk == v.cpol, "R9", "idle level after frame", int'(sclk), int'(v.cpol));
    chk(rise_cnt == exp_rises, tg, "serial clock count", rise_cnt, exp_rises);
    for (int i = 0; i < exp_rises && i < rise_cnt && i < 512; i++)
      if (rec_dq[i] !== exp_dq[i] || rec_oe[i] !== exp_oe[i]) bad++;
    chk(bad == 0, tg, "lane stream mismatches", bad, 0);
    chk(rx_cnt == exp_rx_n, "R3", "received byte count", rx_cnt, exp_rx_n);
    bad = 0;
    for (int i = 0; i < exp_rx_n && i < rx_cnt && i < 64; i++)
      if (rx_rec[i] !== exp_rx[i]) bad++;
    chk(bad == 0, "R3", "received byte mismatches", bad, 0);
    chk(tx_idx == exp_tx_n, "R2", "command bytes taken", tx_idx, exp_tx_n);
    if (rise_cnt >= 2) begin
      int per = 2 * ((v.div == 0) ? 1 : int'(v.div));
      chk(rec_t[1] - rec_t[0] == per, "R8", "serial clock period", rec_t[1] - rec_t[0], per);
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; total = '0; cmd = '0; idle = '0; mode = '0;
    quad = 1'b0; div = 4'd1; cpol = 1'b0; tx_valid = 1'b0; rx_space = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready && cs_n, "R1 R10", "reset ready/cs", int'(ready), 1);
    chk(dq_oe == 4'b0000 && !tx_ready && !rx_valid, "R10 R3", "reset drive/strobes", int'(dq_oe), 0);
    chk(sclk == 1'b0, "R9", "reset idle level", int'(sclk), 0);

    // R1: zero total ignored
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    chk(ready && cs_n && rise_cnt == 0, "R1", "zero-length start ignored", rise_cnt, 0);

    for (int i = 0; i < 9; i++) run_frame(VEC[i], 0);

    // R12: transmit stall, then receive stall
    run_frame('{8'd3, 8'd2, 4'd0, 2'b00, 1'b0, 4'd1, 1'b0}, 1);
    run_frame('{8'd4, 8'd2, 4'd1, 2'b00, 1'b0, 4'd1, 1'b0}, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule